// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Controller

This block gathers per-channel event pulses from a multi-channel DMA engine (up to eight channels) and records them in one 32-bit status word. There are three event classes: transfer error, transfer abort and transfer complete. Software reads the word through a small register port and clears individual flags by writing ones. A per-flag suppress mask gates the flags into one registered interrupt line. A set bit in that mask silences the matching flag.

The same register port carries a set-only abort request register, which issues one-cycle abort pulses to the selected channels, and a read-only view of which channels are currently enabled. For each channel the block also reports whether it is still ongoing, meaning that none of its three flags is set.

Top module: `dma_irq_status_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_err_i[n]`, `evt_abt_i[n]` or `evt_tc_i[n]` sets status bit n, 8+n or 16+n respectively at the next clock edge. The status word is read at register address 0.
- R2: A write to address 0 clears every status bit whose write-data bit is 1. Status bits written with 0 keep their value.
- R3: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: Address 1 holds the suppress mask, with the same bit layout as the status word. A write replaces it. After reset every implemented mask bit is 1.
- R5: `irq_o` is a register. After each edge it equals the OR over all bits of (status AND NOT mask), using the values that both registers take at that edge.
- R6: A write to address 2 makes `abort_req_o` equal the written bits [NUM_CH-1:0] for exactly the following cycle, then zero. Reading address 2 returns the pending pulse bits, and writing 0 bits has no effect.
- R7: Address 3 reads back `ch_enabled_i` zero-extended. Writes to address 3 change nothing.
- R8: `ongoing_o[n]` is 1 exactly when status bits n, 8+n and 16+n are all clear.
- R9: Status and mask bits 24 to 31, and the bits of channels at or above NUM_CH, read as zero and ignore writes.
- R10: After reset, status, abort pulses and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_err_i | input | NUM_CH | Per-channel error event pulses |
| evt_abt_i | input | NUM_CH | Per-channel abort-done event pulses |
| evt_tc_i | input | NUM_CH | Per-channel transfer-complete event pulses |
| ch_enabled_i | input | NUM_CH | Per-channel enabled-and-active indication |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select (0 status, 1 mask, 2 abort, 3 enabled) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected address (combinational) |
| irq_o | output | 1 | Combined interrupt, registered |
| abort_req_o | output | NUM_CH | One-cycle abort request pulses |
| ongoing_o | output | NUM_CH | Channel has no flag set |

## Verification
The bench targets the cycle in which an event and a clearing write land on the same bit. A design that gives the clear priority would lose a completion. It also checks unimplemented channel bits and the top byte. A design that stores those bits would read back ones after an all-ones write. The interrupt is checked in the edge where the mask changes, because a design that computes it from old state would raise or drop `irq_o` one cycle late. The abort pulse is checked to last exactly one cycle, because a design that keeps it would re-abort a channel that has already stopped.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int LANE_W  = 8;
    localparam int N_CLASS = 3;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_ABORT  = 2'd2,
        SEL_CHEN   = 2'd3
    } reg_sel_e;

    // Replicate a per-channel vector into the three byte lanes.
    function automatic logic [31:0] spread_lanes(input logic [LANE_W-1:0] v);
        return {8'h00, v, v, v};
    endfunction
endpackage

// File: rtl/dma_irq_flag_lane.sv
module dma_irq_flag_lane #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] flag_d_o,
    output logic [NUM_CH-1:0] flag_q_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] flag;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // set wins over clear
        st_d.flag = (st_q.flag & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_d_o = st_d.flag;
    assign flag_q_o = st_q.flag;
endmodule

// File: rtl/dma_irq_abort_pulse.sv
module dma_irq_abort_pulse #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [NUM_CH-1:0] bits_i,
    output logic [NUM_CH-1:0] req_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] req;
    } abt_st_t;

    abt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = wr_i ? bits_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;
endmodule

// File: rtl/dma_irq_status_ctrl.sv
module dma_irq_status_ctrl
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_err_i,
    input  logic [NUM_CH-1:0] evt_abt_i,
    input  logic [NUM_CH-1:0] evt_tc_i,
    input  logic [NUM_CH-1:0] ch_enabled_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o,
    output logic [NUM_CH-1:0] abort_req_o,
    output logic [NUM_CH-1:0] ongoing_o
);
    localparam logic [LANE_W-1:0] CH_IMPL  = LANE_W'((2 ** NUM_CH) - 1);
    localparam logic [31:0]       IMPL_WORD = spread_lanes(CH_IMPL);

    typedef struct packed {
        logic [31:0] mask;
        logic        irq;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic [N_CLASS-1:0][NUM_CH-1:0] evt_cls;
    logic [N_CLASS-1:0][NUM_CH-1:0] clr_cls;
    logic [N_CLASS-1:0][NUM_CH-1:0] flag_d;
    logic [N_CLASS-1:0][NUM_CH-1:0] flag_q;
    logic [31:0]                    status_next;
    logic [31:0]                    status_word;
    logic [31:0]                    mask_word;
    logic                           wr_status;
    logic                           wr_mask;
    logic                           wr_abort;

    assign wr_status = reg_wr_i && (reg_addr_i == SEL_STATUS);
    assign wr_mask   = reg_wr_i && (reg_addr_i == SEL_MASK);
    assign wr_abort  = reg_wr_i && (reg_addr_i == SEL_ABORT);

    assign evt_cls[0] = evt_err_i;
    assign evt_cls[1] = evt_abt_i;
    assign evt_cls[2] = evt_tc_i;

    for (genvar k = 0; k < N_CLASS; k++) begin : g_lane
        assign clr_cls[k] = wr_status ? reg_wdata_i[k*LANE_W +: NUM_CH] : '0;

        dma_irq_flag_lane #(.NUM_CH(NUM_CH)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_cls[k]),
            .clr_i    (clr_cls[k]),
            .flag_d_o (flag_d[k]),
            .flag_q_o (flag_q[k])
        );
    end

    dma_irq_abort_pulse #(.NUM_CH(NUM_CH)) u_abort (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_abort),
        .bits_i (reg_wdata_i[NUM_CH-1:0]),
        .req_o  (abort_req_o)
    );

    // Pack lane flags into the status word (current and next).
    always_comb begin
        status_word = '0;
        status_next = '0;
        for (int k = 0; k < N_CLASS; k++) begin
            status_word[k*LANE_W +: NUM_CH] = flag_q[k];
            status_next[k*LANE_W +: NUM_CH] = flag_d[k];
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (wr_mask) ctl_d.mask = reg_wdata_i & IMPL_WORD;
        ctl_d.irq = |(status_next & ~ctl_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mask <= IMPL_WORD;
            ctl_q.irq  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mask_word = ctl_q.mask;
    assign irq_o     = ctl_q.irq;
    assign ongoing_o = ~(flag_q[0] | flag_q[1] | flag_q[2]);

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            SEL_STATUS: reg_rdata_o = status_word;
            SEL_MASK:   reg_rdata_o = mask_word;
            SEL_ABORT:  reg_rdata_o[NUM_CH-1:0] = abort_req_o;
            default:    reg_rdata_o[NUM_CH-1:0] = ch_enabled_i;
        endcase
    end
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] evt_err_i,
    input logic [NUM_CH-1:0] evt_abt_i,
    input logic [NUM_CH-1:0] evt_tc_i,
    input logic              reg_wr_i,
    input logic [1:0]        reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic              irq_o,
    input logic [NUM_CH-1:0] abort_req_o,
    input logic [NUM_CH-1:0] ongoing_o,
    input logic [31:0]       status_word,
    input logic [31:0]       mask_word
);
    p_tc_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_tc_i != '0) |=> ((status_word[16 +: NUM_CH] & $past(evt_tc_i)) == $past(evt_tc_i)));

    p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd0 && evt_err_i == '0 && evt_abt_i == '0 && evt_tc_i == '0)
        |=> ((status_word & $past(reg_wdata_i)) == 32'd0));

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 2'd0 && evt_err_i != '0)
        |=> ((status_word[NUM_CH-1:0] & $past(evt_err_i)) == $past(evt_err_i)));

    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(status_word & ~mask_word));

    p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == 2'd2) |=> (abort_req_o == '0));

    p_ongoing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ongoing_o == ~(status_word[NUM_CH-1:0] | status_word[8 +: NUM_CH] | status_word[16 +: NUM_CH]));

    p_top_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[31:24] == 8'h00) && (mask_word[31:24] == 8'h00));
endmodule

bind dma_irq_status_ctrl dma_irq_status_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_err_i   (evt_err_i),
    .evt_abt_i   (evt_abt_i),
    .evt_tc_i    (evt_tc_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .abort_req_o (abort_req_o),
    .ongoing_o   (ongoing_o),
    .status_word (status_word),
    .mask_word   (mask_word)
);

// File: tb/dma_irq_status_ctrl_tb.sv
module dma_irq_status_ctrl_tb;
    localparam int NC = 6;
    localparam logic [7:0] IMPL = 8'h3F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] evt_err = '0, evt_abt = '0, evt_tc = '0, ch_en = '0;
    logic          wr = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;
    logic [NC-1:0] abreq, ongoing;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit running = 1'b0;

    always #5 clk = ~clk;

    dma_irq_status_ctrl #(.NUM_CH(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_err_i(evt_err), .evt_abt_i(evt_abt),
        .evt_tc_i(evt_tc), .ch_enabled_i(ch_en), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
        .abort_req_o(abreq), .ongoing_o(ongoing)
    );

    // Behavioural reference model
    logic [7:0]  m_err, m_abt, m_tc, m_req;
    logic [31:0] m_mask;
    bit          m_irq;

    function automatic logic [31:0] m_status();
        return {8'h00, m_tc, m_abt, m_err};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_err = 0; m_abt = 0; m_tc = 0; m_req = 0; m_irq = 0;
            m_mask = {8'h00, IMPL, IMPL, IMPL};
        end else begin
            logic [31:0] clr;
            clr = (wr && addr == 2'd0) ? wdata : 32'd0;
            m_err = ((m_err & ~clr[7:0])   | 8'(evt_err)) & IMPL;
            m_abt = ((m_abt & ~clr[15:8])  | 8'(evt_abt)) & IMPL;
            m_tc  = ((m_tc  & ~clr[23:16]) | 8'(evt_tc))  & IMPL;
            if (wr && addr == 2'd1) m_mask = wdata & {8'h00, IMPL, IMPL, IMPL};
            m_req = (wr && addr == 2'd2) ? (wdata[7:0] & IMPL) : 8'h00;
            m_irq = (m_status() & ~m_mask) != 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0: return m_status();
            2'd1: return m_mask;
            2'd2: return {24'h0, m_req};
            default: return {24'h0, 8'(ch_en)};
        endcase
    endfunction

    // per-cycle comparison, before the bench drives new inputs
    always @(negedge clk) if (running) begin
        check("R5 irq", {31'h0, irq}, {31'h0, m_irq});
        check("R6 abort_req", 32'(abreq), {24'h0, m_req});
        check("R8 ongoing", 32'(ongoing),
              32'(~(m_err | m_abt | m_tc) & IMPL));
        case (addr)
            2'd0: check("R1 status", rdata, m_rdata(addr));
            2'd1: check("R4 mask", rdata, m_rdata(addr));
            2'd2: check("R6 abort reg", rdata, m_rdata(addr));
            default: check("R7 enabled", rdata, m_rdata(addr));
        endcase
    end

    task automatic cyc(input bit w, input logic [1:0] a, input logic [31:0] d,
                       input logic [NC-1:0] e, input logic [NC-1:0] ab, input logic [NC-1:0] t);
        @(negedge clk); #1;
        wr = w; addr = a; wdata = d; evt_err = e; evt_abt = ab; evt_tc = t;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, a, 32'd0, '0, '0, '0);
        #1 check(tag, rdata, exp);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        running = 1'b1;
        repeat (3) @(negedge clk);
        #1 check("R10 status at reset", rdata, 32'd0);
        check("R10 irq at reset", {31'h0, irq}, 32'd0);
        rst_n = 1'b1;
        rd_chk(2'd1, 32'h003F3F3F, "R4 mask reset");
        rd_chk(2'd2, 32'd0, "R10 abort idle");

        // R1: error on channel 2, masked so no irq
        cyc(1'b0, 2'd0, 0, 6'h04, 0, 0);
        rd_chk(2'd0, 32'h0000_0004, "R1 err ch2");
        check("R5 masked irq low", {31'h0, irq}, 32'd0);
        // R5: unmask all
        cyc(1'b1, 2'd1, 32'h0, 0, 0, 0);
        rd_chk(2'd0, 32'h0000_0004, "R4 status unchanged by mask write");
        check("R5 irq after unmask", {31'h0, irq}, 32'd1);
        // R2: write zero keeps, write one clears
        cyc(1'b1, 2'd0, 32'h0, 0, 0, 0);
        rd_chk(2'd0, 32'h0000_0004, "R2 zero write keeps");
        cyc(1'b1, 2'd0, 32'h4, 0, 0, 0);
        rd_chk(2'd0, 32'h0, "R2 one write clears");
        check("R5 irq drops", {31'h0, irq}, 32'd0);
        // R3: collision of event and clear on bit 17
        cyc(1'b0, 2'd0, 0, 0, 0, 6'h02);
        cyc(1'b1, 2'd0, 32'h0002_0000, 0, 0, 6'h02);
        rd_chk(2'd0, 32'h0002_0000, "R3 set wins");
        check("R8 ch1 not ongoing", 32'(ongoing), 32'h3D);
        // R1 abort lane
        cyc(1'b0, 2'd0, 0, 0, 6'h20, 0);
        rd_chk(2'd0, 32'h0002_2000, "R1 abort ch5");
        // R9: all-ones writes
        cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0);
        rd_chk(2'd0, 32'h0, "R9 status all-ones clear");
        cyc(1'b1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0);
        rd_chk(2'd1, 32'h003F_3F3F, "R9 mask upper bits");
        // R6: abort pulse, unimplemented bit 7 ignored
        cyc(1'b1, 2'd2, 32'h0000_0081, 0, 0, 0);
        cyc(1'b0, 2'd2, 0, 0, 0, 0);
        #1 check("R6 pulse present", 32'(abreq), 32'h01);
        check("R6 reg readback", rdata, 32'h01);
        cyc(1'b0, 2'd2, 0, 0, 0, 0);
        #1 check("R6 pulse gone", 32'(abreq), 32'h0);
        // R7: enabled view, writes ignored
        ch_en = 6'h2A;
        cyc(1'b1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0);
        rd_chk(2'd3, 32'h0000_002A, "R7 enabled view");
        rd_chk(2'd1, 32'h003F_3F3F, "R7 write to enabled leaves mask");

        // random traffic, compared every cycle
        for (int i = 0; i < 4000; i++) begin
            logic [NC-1:0] e, ab, t;
            e  = ($urandom % 4 == 0) ? NC'($urandom) : '0;
            ab = ($urandom % 6 == 0) ? NC'($urandom) : '0;
            t  = ($urandom % 4 == 0) ? NC'($urandom) : '0;
            if (i % 97 == 0) ch_en = NC'($urandom);
            cyc(($urandom % 3) == 0, 2'($urandom), $urandom, e, ab, t);
        end
        cyc(1'b0, 2'd0, 0, 0, 0, 0);
        @(negedge clk); #1;
        running = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule